// File: doc/BRIEF.md
# Flash In-System Programming Command Sequencer

This block lets software reprogram an on-chip flash through a handful of registers. Software loads a target address, up to four data words and a command code, then writes a start bit. The sequencer spends one cycle validating the request. It checks the command code, the address alignment, whether the address falls inside a known region, the per-region update permissions and the brown-out input. Only if every check passes does it drive a simple flash port. That port has read, program, page-erase and mass-erase strobes, and each strobe is held until the flash answers with a ready pulse.

A request that fails any check never reaches the flash. It raises a sticky fail flag, and the start bit drops on the following cycle. Reads return flash data into the data words. Wide operations walk the address up one word per beat. A write-protect input stands in for the chip-level unlock sequence and gates writes to the control, command and start registers. A boot-source bit is also kept here. It is loaded from a strap input at reset and can be rewritten by software.

Top module: `flash_isp_seq`

## Requirements
- R1: Valid command codes are 0x00 (32-bit read, 1 beat), 0x21 (32-bit program, 1 beat), 0x22 (page erase, 1 beat), 0x26 (mass erase, 1 beat), 0x27 (four-word program, 4 beats), 0x40 (64-bit read, 2 beats) and 0x61 (64-bit program, 2 beats). Every other 7-bit code is invalid: it sets the fail flag and asserts no flash strobe.
- R2: Writing 1 to bit 0 of the start register begins an operation, provided the ISP enable bit is 1. The busy output and the status busy bit mirror the start bit, which clears by itself after the last beat's ready. While busy, writes to the address, command, data and start registers are ignored.
- R3: A program or page erase to the application region fails when its update enable is 0, and the same rule holds for the boot-loader region and the config region with their own enables. Mass erase fails unless both the application and boot-loader enables are 1.
- R4: While brown-out is detected, program, page-erase and mass-erase requests fail. Reads are not affected.
- R5: Any command other than mass erase fails when its address lies outside the application region [0x0,0x1000), the boot-loader region [0x100000,0x100800) and the config region [0x300000,0x300010).
- R6: The address is illegal and fails if any of these bits is nonzero: bits [1:0] for 0x00, 0x21 and 0x22; bits [2:0] for 0x40 and 0x61; bits [3:0] for 0x27.
- R7: The fail flag is sticky and clears only when 1 is written to its control bit. When a check fails, the start bit is already 0 on the cycle after the check, and no strobe is asserted for that request.
- R8: With the write-protect input closed (0), writes to the control, command and start registers have no effect.
- R9: The boot-select bit resets to the strap input and drives the next-boot output: 0 selects the application region and 1 selects the boot-loader region.
- R10: Each read beat stores the flash data into data word N on its ready, where N is the beat number. Beat N uses address base+4N.
- R11: Each program beat N presents data word N at address base+4N. Each strobe is one-hot and is held with a stable address until ready.
- R12: Register select map: 0 control, 1 address, 2 command, 3 start, 4 status, 5..8 data words 0..3. Control bits: [0] ISP enable, [1] boot select, [2] config update enable, [3] application update enable, [4] boot-loader update enable, [5] fail (write 1 to clear). Status bits: [0] busy, [1] fail, [2] boot select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_open | input | 1 | Write-protect unlocked |
| bod_det | input | 1 | Brown-out detected |
| boot_init_ldr | input | 1 | Reset value of boot select |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| busy | output | 1 | Operation in progress |
| fail | output | 1 | Sticky fail flag |
| next_boot_ldr | output | 1 | Next boot from boot-loader region |
| fl_rd | output | 1 | Flash read strobe |
| fl_prog | output | 1 | Flash program strobe |
| fl_erase | output | 1 | Flash page-erase strobe |
| fl_mass | output | 1 | Flash mass-erase strobe |
| fl_addr | output | 32 | Flash byte address |
| fl_wdata | output | 32 | Flash program data |
| fl_rdata | input | 32 | Flash read data |
| fl_ready | input | 1 | Flash beat complete |

## Verification
The bench sweeps all 128 command codes. A decoder that accepted one stray code would strobe the flash where it must not, and one that rejected a listed code would raise fail. It also sweeps the low address nibble for each alignment class, because a wrong mask width would pass a misaligned 64-bit or four-word access or reject a legal one. Permission, brown-out, range and lock cases are each checked both for the fail flag and for the absence of any strobe. A design that set the flag but still issued the cycle would therefore be caught. Multi-beat reads and programs are checked word by word, which exposes an address step or data-word index that is off by one.

// File: rtl/flash_isp_seq.sv
module flash_isp_seq #(
  parameter logic [31:0] APP_BASE = 32'h0000_0000,
  parameter logic [31:0] APP_SIZE = 32'h0000_1000,
  parameter logic [31:0] LDR_BASE = 32'h0010_0000,
  parameter logic [31:0] LDR_SIZE = 32'h0000_0800,
  parameter logic [31:0] CFG_BASE = 32'h0030_0000,
  parameter logic [31:0] CFG_SIZE = 32'h0000_0010,
  parameter int          NWORDS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wp_open,
  input  logic        bod_det,
  input  logic        boot_init_ldr,
  input  logic        reg_wr,
  input  logic [3:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        fail,
  output logic        next_boot_ldr,
  output logic        fl_rd,
  output logic        fl_prog,
  output logic        fl_erase,
  output logic        fl_mass,
  output logic [31:0] fl_addr,
  output logic [31:0] fl_wdata,
  input  logic [31:0] fl_rdata,
  input  logic        fl_ready
);
  localparam logic [3:0] SEL_CTRL = 4'd0;
  localparam logic [3:0] SEL_ADDR = 4'd1;
  localparam logic [3:0] SEL_CMD  = 4'd2;
  localparam logic [3:0] SEL_GO   = 4'd3;
  localparam logic [3:0] SEL_STAT = 4'd4;
  localparam logic [3:0] SEL_DAT0 = 4'd5;
  localparam int         BW       = $clog2(NWORDS);

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_RUN} st_t;
  st_t st;

  logic          isp_en, boot_ldr, cfg_upd, app_upd, ldr_upd, fail_q, go_q;
  logic [31:0]   addr_q;
  logic [6:0]    cmd_q;
  logic [31:0]   dat_q [NWORDS];
  logic [BW-1:0] beat, last_beat;

  wire c_rd    = cmd_q == 7'h00;
  wire c_prog  = cmd_q == 7'h21;
  wire c_perase= cmd_q == 7'h22;
  wire c_mass  = cmd_q == 7'h26;
  wire c_mprog = cmd_q == 7'h27;
  wire c_rd64  = cmd_q == 7'h40;
  wire c_prog64= cmd_q == 7'h61;

  wire cmd_ok   = c_rd | c_prog | c_perase | c_mass | c_mprog | c_rd64 | c_prog64;
  wire is_write = c_prog | c_perase | c_mprog | c_prog64;
  wire is_mod   = is_write | c_mass;
  wire is_read  = c_rd | c_rd64;

  assign last_beat = c_mprog ? BW'(NWORDS - 1) : (c_rd64 | c_prog64) ? BW'(1) : '0;

  wire in_app = (addr_q - APP_BASE) < APP_SIZE;
  wire in_ldr = (addr_q - LDR_BASE) < LDR_SIZE;
  wire in_cfg = (addr_q - CFG_BASE) < CFG_SIZE;

  wire misalign = (c_mprog & |addr_q[3:0])
                | ((c_rd64 | c_prog64) & |addr_q[2:0])
                | ((c_rd | c_prog | c_perase) & |addr_q[1:0]);
  wire out_rng  = !c_mass & !(in_app | in_ldr | in_cfg);
  wire perm_bad = (is_write & ((in_app & !app_upd) | (in_ldr & !ldr_upd) | (in_cfg & !cfg_upd)))
                | (c_mass & !(app_upd & ldr_upd));
  wire bod_bad  = is_mod & bod_det;
  wire violation = !cmd_ok | misalign | out_rng | perm_bad | bod_bad;

  wire set_fail = (st == S_CHK) && violation;
  wire wr_ctrl  = reg_wr && wp_open && reg_sel == SEL_CTRL;
  wire wr_addr  = reg_wr && !go_q && reg_sel == SEL_ADDR;
  wire wr_cmd   = reg_wr && wp_open && !go_q && reg_sel == SEL_CMD;
  wire wr_go    = reg_wr && wp_open && !go_q && isp_en && reg_sel == SEL_GO && reg_wdata[0];
  wire beat_hs  = (st == S_RUN) && fl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {isp_en, cfg_upd, app_upd, ldr_upd} <= '0;
      boot_ldr <= boot_init_ldr;
    end else if (wr_ctrl) begin
      isp_en   <= reg_wdata[0];
      boot_ldr <= reg_wdata[1];
      cfg_upd  <= reg_wdata[2];
      app_upd  <= reg_wdata[3];
      ldr_upd  <= reg_wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         fail_q <= 1'b0;
    else if (set_fail)                  fail_q <= 1'b1;
    else if (wr_ctrl && reg_wdata[5])   fail_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (wr_addr) addr_q <= reg_wdata;
      if (wr_cmd)  cmd_q  <= reg_wdata[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      go_q <= 1'b0;
      beat <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (wr_go) begin
          go_q <= 1'b1;
          beat <= '0;
          st   <= S_CHK;
        end
        S_CHK: if (violation) begin
          go_q <= 1'b0;
          st   <= S_IDLE;
        end else begin
          st   <= S_RUN;
        end
        S_RUN: if (fl_ready) begin
          if (beat == last_beat) begin
            go_q <= 1'b0;
            st   <= S_IDLE;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_dat
    always_ff @(posedge clk) begin
      if (!rst_n)
        dat_q[i] <= '0;
      else if (beat_hs && is_read && beat == BW'(i))
        dat_q[i] <= fl_rdata;
      else if (reg_wr && !go_q && reg_sel == SEL_DAT0 + 4'(i))
        dat_q[i] <= reg_wdata;
    end
  end

  wire run = st == S_RUN;
  assign fl_rd    = run & is_read;
  assign fl_prog  = run & (c_prog | c_prog64 | c_mprog);
  assign fl_erase = run & c_perase;
  assign fl_mass  = run & c_mass;
  assign fl_addr  = addr_q + {{(30-BW){1'b0}}, beat, 2'b00};
  assign fl_wdata = dat_q[beat];

  assign busy          = go_q;
  assign fail          = fail_q;
  assign next_boot_ldr = boot_ldr;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: reg_rdata = {26'd0, fail_q, ldr_upd, app_upd, cfg_upd, boot_ldr, isp_en};
      SEL_ADDR: reg_rdata = addr_q;
      SEL_CMD:  reg_rdata = {25'd0, cmd_q};
      SEL_GO:   reg_rdata = {31'd0, go_q};
      SEL_STAT: reg_rdata = {29'd0, boot_ldr, fail_q, go_q};
      default: begin
        for (int i = 0; i < NWORDS; i++)
          if (reg_sel == SEL_DAT0 + 4'(i)) reg_rdata = dat_q[i];
      end
    endcase
  end

  wire any_strobe = fl_rd | fl_prog | fl_erase | fl_mass;

  a_r11_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_rd, fl_prog, fl_erase, fl_mass}));

  a_r2_strobe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> busy);

  a_r7_fail_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> !go_q && !any_strobe);

  a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && !fl_ready) |=> $stable({fl_rd, fl_prog, fl_erase, fl_mass, fl_addr}));

  a_r8_locked_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wp_open) |=> $stable({cmd_q, isp_en, boot_ldr, cfg_upd, app_upd, ldr_upd}));

  a_r2_go_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_q) |-> $past(set_fail) || $past(beat_hs));
endmodule

// File: tb/flash_isp_seq_tb.sv
module flash_isp_seq_tb;
  logic clk = 0, rst_n = 0, wp_open = 1, bod_det = 0, boot_init_ldr = 1;
  logic reg_wr = 0;
  logic [3:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic busy, fail, next_boot_ldr, fl_rd, fl_prog, fl_erase, fl_mass;
  logic [31:0] fl_addr, fl_wdata, fl_rdata;
  logic fl_ready = 0;

  localparam logic [31:0] KEY = 32'hC3A5_5A3C;
  localparam logic [31:0] ALL_EN = 32'h1D;

  int checks = 0, fails = 0;
  int n_strobe = 0, n_prog = 0, n_rd = 0, n_erase = 0, n_mass = 0;
  logic [31:0] plog_a [8];
  logic [31:0] plog_d [8];

  always #2.5 clk = ~clk;

  flash_isp_seq u_dut (.*);

  assign fl_rdata = fl_addr ^ KEY;
  wire any_s = fl_rd | fl_prog | fl_erase | fl_mass;

  always @(posedge clk) begin
    if (!rst_n) fl_ready <= 0;
    else        fl_ready <= any_s && !fl_ready;
    if (any_s) n_strobe <= n_strobe + 1;
    if (any_s && fl_ready) begin
      if (fl_prog) begin
        plog_a[n_prog % 8] <= fl_addr;
        plog_d[n_prog % 8] <= fl_wdata;
        n_prog <= n_prog + 1;
      end
      if (fl_rd)    n_rd    <= n_rd + 1;
      if (fl_erase) n_erase <= n_erase + 1;
      if (fl_mass)  n_mass  <= n_mass + 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [3:0] s, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(logic [3:0] s, output logic [31:0] d);
    reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic run_op(logic [6:0] c, logic [31:0] a);
    wreg(1, a);
    wreg(2, {25'd0, c});
    wreg(3, 1);
    for (int k = 0; k < 40 && busy; k++) @(negedge clk);
  endtask

  function automatic bit valid_cmd(int c);
    return c == 'h00 || c == 'h21 || c == 'h22 || c == 'h26 || c == 'h27 || c == 'h40 || c == 'h61;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0, p0, m0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rreg(0, v);  check("R9 reset ctrl", v, 32'h2);
    check("R9 next boot reset", {31'd0, next_boot_ldr}, 1);
    rreg(4, v);  check("R12 reset status", v, 32'h4);
    check("R2 busy reset", {31'd0, busy}, 0);

    // R8: locked writes
    wp_open = 0;
    wreg(0, 32'h1D); rreg(0, v); check("R8 ctrl locked", v, 32'h2);
    wreg(2, 32'h21); rreg(2, v); check("R8 cmd locked", v, 0);
    wp_open = 1;
    wreg(0, 32'h1D | 32'h2);
    wp_open = 0;
    s0 = n_strobe;
    wreg(1, 32'h100); wreg(3, 1); repeat (4) @(negedge clk);
    check("R8 go locked", n_strobe - s0, 0);
    rreg(1, v); check("R8 addr not locked", v, 32'h100);
    wp_open = 1;

    // R2: go ignored with ISP disabled
    wreg(0, 32'h1C); s0 = n_strobe;
    run_op(7'h00, 32'h100); repeat (3) @(negedge clk);
    check("R2 go ignored when disabled", n_strobe - s0, 0);

    // R9 boot select
    wreg(0, ALL_EN);
    check("R9 next boot app", {31'd0, next_boot_ldr}, 0);

    // R10 32-bit read
    run_op(7'h00, 32'h104);
    rreg(5, v); check("R10 read32 data", v, 32'h104 ^ KEY);
    check("R10 read32 no fail", {31'd0, fail}, 0);

    // R2 busy mirror and write-ignore while busy; R10 64-bit read
    wreg(1, 32'h208); wreg(2, 32'h40); wreg(3, 1);
    rreg(4, v); check("R2 status busy", v & 1, 1);
    rreg(3, v); check("R2 go reads 1", v, 1);
    wreg(1, 32'h300);
    for (int k = 0; k < 40 && busy; k++) @(negedge clk);
    rreg(1, v); check("R2 addr write ignored while busy", v, 32'h208);
    rreg(5, v); check("R10 read64 word0", v, 32'h208 ^ KEY);
    rreg(6, v); check("R10 read64 word1", v, 32'h20C ^ KEY);

    // R11 multi-word and 64-bit program
    for (int i = 0; i < 4; i++) wreg(4'(5 + i), 32'hA000_0000 + 32'(i * 17));
    p0 = n_prog;
    run_op(7'h27, 32'h0400);
    check("R11 multi beats", n_prog - p0, 4);
    for (int i = 0; i < 4; i++) begin
      check("R11 multi addr", plog_a[(p0 + i) % 8], 32'h400 + 32'(4 * i));
      check("R11 multi data", plog_d[(p0 + i) % 8], 32'hA000_0000 + 32'(i * 17));
    end
    p0 = n_prog;
    run_op(7'h61, 32'h0808);
    check("R11 prog64 beats", n_prog - p0, 2);
    check("R11 prog64 addr1", plog_a[(p0 + 1) % 8], 32'h80C);
    check("R11 prog64 data1", plog_d[(p0 + 1) % 8], 32'hA000_0011);

    // R3 permissions
    wreg(0, 32'h15); s0 = n_strobe;
    run_op(7'h21, 32'h10);
    check("R3 app locked fail", {31'd0, fail}, 1);
    check("R7 no strobe on fail", n_strobe - s0, 0);
    check("R7 go cleared", {31'd0, busy}, 0);
    run_op(7'h00, 32'h10);
    check("R7 fail sticky", {31'd0, fail}, 1);
    wreg(0, ALL_EN | 32'h20);
    check("R7 fail cleared by w1", {31'd0, fail}, 0);
    wreg(0, 32'h0D); run_op(7'h22, 32'h100000);
    check("R3 ldr locked fail", {31'd0, fail}, 1);
    wreg(0, 32'h1D | 32'h20);
    run_op(7'h22, 32'h100000);
    check("R3 ldr erase ok", {31'd0, fail}, 0);
    wreg(0, 32'h19); run_op(7'h21, 32'h300004);
    check("R3 cfg locked fail", {31'd0, fail}, 1);
    wreg(0, 32'h0D | 32'h20); m0 = n_mass;
    run_op(7'h26, 32'h0);
    check("R3 mass needs ldr enable", {31'd0, fail}, 1);
    wreg(0, ALL_EN | 32'h20);
    run_op(7'h26, 32'hFFFF_FFF3);
    check("R3 mass ok any addr", n_mass - m0, 1);
    check("R5 mass no range check", {31'd0, fail}, 0);

    // R4 brown-out
    bod_det = 1; s0 = n_strobe;
    run_op(7'h21, 32'h20);
    check("R4 bod blocks program", {31'd0, fail}, 1);
    check("R4 bod no strobe", n_strobe - s0, 0);
    wreg(0, ALL_EN | 32'h20);
    run_op(7'h00, 32'h20);
    check("R4 bod read ok", {31'd0, fail}, 0);
    bod_det = 0;

    // R5 range
    run_op(7'h00, 32'h1000);
    check("R5 out of range", {31'd0, fail}, 1);
    wreg(0, ALL_EN | 32'h20);
    run_op(7'h00, 32'h30000C);
    check("R5 cfg in range", {31'd0, fail}, 0);

    // R1 sweep of every command code
    for (int c = 0; c < 128; c++) begin
      s0 = n_strobe;
      run_op(7'(c), 32'h0);
      check("R1 cmd fail", {31'd0, fail}, valid_cmd(c) ? 0 : 1);
      check("R1 cmd strobe", {31'd0, (n_strobe - s0) > 0}, valid_cmd(c) ? 1 : 0);
      wreg(0, ALL_EN | 32'h20);
    end

    // R6 alignment sweep
    for (int j = 0; j < 6; j++) begin
      logic [6:0] c;
      logic [3:0] m;
      case (j)
        0: begin c = 7'h00; m = 4'h3; end
        1: begin c = 7'h21; m = 4'h3; end
        2: begin c = 7'h22; m = 4'h3; end
        3: begin c = 7'h40; m = 4'h7; end
        4: begin c = 7'h61; m = 4'h7; end
        default: begin c = 7'h27; m = 4'hF; end
      endcase
      for (int lo = 0; lo < 16; lo++) begin
        s0 = n_strobe;
        run_op(c, 32'h0100 + 32'(lo));
        check("R6 align fail", {31'd0, fail}, ((4'(lo) & m) != 0) ? 1 : 0);
        if ((4'(lo) & m) != 0) check("R6 misaligned no strobe", n_strobe - s0, 0);
        wreg(0, ALL_EN | 32'h20);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule